// File: doc/BRIEF.md
# Tagged Translation Cache with Selective Invalidation

This block is a small fully associative translation cache. Each slot holds a virtual page number, a physical page number, an address-space identifier, a virtual-machine identifier, a non-secure flag, a hypervisor flag, a two-bit privilege level, a host-regime flag and a valid bit. A lookup compares every slot in parallel. It resolves to the lowest-numbered matching slot and returns the physical page one cycle after the request is accepted. A slot found beyond a configurable recently-used window is moved to the front. Debug probes never reorder the slots.

Three channels reach the block, and each uses a valid/ready handshake: lookups, refills and invalidation commands. An invalidation is latched and then applied as a sweep that visits one slot per cycle. While the sweep runs, all three channels are held off. A refill uses the lowest free slot and falls back to a rotating pointer when the cache is full. When a first-stage instance running in hypervisor mode accepts a flush-all command, it raises a strobe so that the second-stage cache is flushed as well.

Top module: `tlb_tagged`

## Requirements
- R1: After reset every slot is invalid, no response is pending, the sweep-busy flag is low, all three ready outputs are high and the forward strobe is low.
- R2: A lookup accepted on a clock edge yields exactly one response cycle right after that edge. The response hits only if a slot is valid and every one of these agrees with the request: page number, VMID, hypervisor flag, level, host flag, and the non-secure flag equal to the inverse of the secure input. The ASID must also agree unless ignore-ASID is set. The lowest matching index wins and is reported with its physical page. A miss reports page 0 and index 0.
- R3: A non-probe hit at an index strictly above MRU_LIMIT moves that slot to index 0 and shifts slots 0 to idx-1 up by one. A probe, or a hit at an index at or below MRU_LIMIT, leaves the order unchanged.
- R4: Opcode 0 (flush all) clears each valid slot that meets all of these: its non-secure flag is the inverse of the command's secure input; its VMID equals the command VMID, or the command is secure; its level and host flag equal the command's, unless ignore-level is set.
- R5: Opcode 1 (flush by ASID) applies the R4 qualifiers with level checking always on, and also requires the slot ASID to equal the command ASID.
- R6: Opcodes 2 (page with ASID) and 3 (page, any ASID) clear every slot that a lookup would hit. For these lookups the hypervisor flag is taken as (command level == 2). Opcode 3 uses the ignore-ASID form of the match.
- R7: Opcode 4 (flush by VMID) clears each valid slot whose VMID equals the command VMID and whose non-secure flag is the inverse of the secure input. Opcodes 5 to 7 clear nothing.
- R8: After an invalidation is accepted, the busy flag stays high for exactly ENTRIES cycles. While it is high, no channel is ready.
- R9: An accepted opcode-0 command with hypervisor mode set, in an instance with IS_STAGE2 = 0, raises the forward strobe for exactly one cycle after the accepting edge. The strobe carries the command's secure input. Any other command leaves the strobe low.
- R10: A refill writes the lowest-numbered invalid slot. If no slot is invalid, it writes the slot at a rotating pointer, which starts at 0 and advances only on such replacements.
- R11: At most one channel is accepted per cycle. Invalidation has priority over refill, and refill has priority over lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request valid |
| lkReady | output | 1 | Lookup request accepted |
| lkVpn | input | VPN_W | Lookup virtual page |
| lkAsid | input | ASID_W | Lookup ASID |
| lkVmid | input | VMID_W | Lookup VMID |
| lkHyp | input | 1 | Lookup hypervisor flag |
| lkSecure | input | 1 | Lookup secure state |
| lkLevel | input | 2 | Lookup target level |
| lkHost | input | 1 | Lookup host-regime flag |
| lkIgnoreAsid | input | 1 | Ignore ASID in the match |
| lkProbe | input | 1 | Debug probe (no reordering) |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Lookup hit |
| rspPpn | output | PPN_W | Physical page on hit |
| rspIdx | output | IDX_W | Slot index on hit |
| refValid | input | 1 | Refill valid |
| refReady | output | 1 | Refill accepted |
| refVpn | input | VPN_W | Refill virtual page |
| refPpn | input | PPN_W | Refill physical page |
| refAsid | input | ASID_W | Refill ASID |
| refVmid | input | VMID_W | Refill VMID |
| refNs | input | 1 | Refill non-secure flag |
| refHyp | input | 1 | Refill hypervisor flag |
| refLevel | input | 2 | Refill level |
| refHost | input | 1 | Refill host-regime flag |
| invValid | input | 1 | Invalidation valid |
| invReady | output | 1 | Invalidation accepted |
| invOp | input | 3 | Invalidation opcode |
| invVpn | input | VPN_W | Page for opcodes 2 and 3 |
| invAsid | input | ASID_W | ASID for opcodes 1 and 2 |
| invVmid | input | VMID_W | Current or target VMID |
| invSecure | input | 1 | Secure state of the command |
| invLevel | input | 2 | Target level |
| invHost | input | 1 | Host-regime flag |
| invIgnoreLevel | input | 1 | Skip level match (opcode 0) |
| invHypMode | input | 1 | Issuer is in hypervisor mode |
| invBusy | output | 1 | Sweep in progress |
| fwdAllValid | output | 1 | Flush-all forward strobe |
| fwdAllSecure | output | 1 | Secure state of forwarded flush |

## Verification
The bench loads the cache with a duplicate page that differs only in ASID and a duplicate that matches exactly. A priority encoder that favoured high indices would return the wrong physical page for these. It drives non-probe hits on both sides of the recently-used limit and then re-probes. An off-by-one in the promotion threshold, or promotion on probes, shows up as a shifted index. The invalidation cases are chosen to separate the qualifiers: secure versus non-secure, a VMID mismatch, a host-regime slot that survives a level-checked flush but not an ignore-level one, and a page flush that must remove two matching slots. Any one of these is broken by a single dropped qualifier. The bench also counts the sweep length and the forward strobe, and it fills the cache past capacity to confirm that the rotating victim advances only on replacements.

// File: rtl/tlb_tag_pkg.sv
package tlb_tag_pkg;

  typedef enum logic [2:0] {
    INV_ALL     = 3'd0,
    INV_ASID    = 3'd1,
    INV_VA_ASID = 3'd2,
    INV_VA_ANY  = 3'd3,
    INV_VMID    = 3'd4
  } invOp_e;

  typedef struct packed {
    logic lkFire;
    logic refFire;
    logic invStart;
    logic sweepOn;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_tag_ctrl.sv
module tlb_tag_ctrl
  import tlb_tag_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter bit IS_STAGE2 = 1'b0,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               refValid,
  input  logic               invValid,
  input  logic [2:0]         invOp,
  input  logic               invHypMode,
  input  logic               invSecure,
  input  logic [ENTRIES-1:0] validVec,
  output logic               lkReady,
  output logic               refReady,
  output logic               invReady,
  output logic               busy,
  output logic [IDX_W-1:0]   sweepIdx,
  output logic [IDX_W-1:0]   refIdx,
  output logic               fwdAllValid,
  output logic               fwdAllSecure,
  output tlbStrobe_t         strb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] firstFree;
  logic             anyFree;

  assign invReady = !busy;
  assign refReady = !busy && !invValid;
  assign lkReady  = !busy && !invValid && !refValid;

  assign strb.invStart = invValid && invReady;
  assign strb.refFire  = refValid && refReady;
  assign strb.lkFire   = lkValid && lkReady;
  assign strb.sweepOn  = busy;

  always_comb begin
    firstFree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) firstFree = IDX_W'(i);
    end
  end

  assign anyFree = !(&validVec);
  assign refIdx  = anyFree ? firstFree : rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sweepIdx <= '0;
    end else if (strb.invStart) begin
      busy     <= 1'b1;
      sweepIdx <= '0;
    end else if (busy) begin
      if (sweepIdx == LAST_IDX) busy <= 1'b0;
      else sweepIdx <= sweepIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strb.refFire && !anyFree) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdAllValid  <= 1'b0;
      fwdAllSecure <= 1'b0;
    end else begin
      fwdAllValid <= strb.invStart && (invOp_e'(invOp) == INV_ALL)
                     && invHypMode && !IS_STAGE2;
      if (strb.invStart) fwdAllSecure <= invSecure;
    end
  end

  // R11: one acceptance per cycle
  p_one_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lkFire, strb.refFire, strb.invStart}));

  // R8: sweep holds every channel off
  p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!lkReady && !refReady && !invReady));

  // R8: sweep ends after the last slot
  p_sweep_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sweepIdx == LAST_IDX) |=> !busy);

  // R9: forward strobe lasts one cycle
  p_fwd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    fwdAllValid |=> !fwdAllValid);

endmodule

// File: rtl/tlb_tag_store.sv
module tlb_tag_store
  import tlb_tag_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int MRU_LIMIT = 2,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strb,
  input  logic [IDX_W-1:0]   sweepIdx,
  input  logic [IDX_W-1:0]   refIdx,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [VMID_W-1:0]  lkVmid,
  input  logic               lkHyp,
  input  logic               lkSecure,
  input  logic [1:0]         lkLevel,
  input  logic               lkHost,
  input  logic               lkIgnoreAsid,
  input  logic               lkProbe,
  input  logic [VPN_W-1:0]   refVpn,
  input  logic [PPN_W-1:0]   refPpn,
  input  logic [ASID_W-1:0]  refAsid,
  input  logic [VMID_W-1:0]  refVmid,
  input  logic               refNs,
  input  logic               refHyp,
  input  logic [1:0]         refLevel,
  input  logic               refHost,
  input  logic [2:0]         invOp,
  input  logic [VPN_W-1:0]   invVpn,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic [VMID_W-1:0]  invVmid,
  input  logic               invSecure,
  input  logic [1:0]         invLevel,
  input  logic               invHost,
  input  logic               invIgnoreLevel,
  output logic [ENTRIES-1:0] validVec,
  output logic               rspValid,
  output logic               rspHit,
  output logic [PPN_W-1:0]   rspPpn,
  output logic [IDX_W-1:0]   rspIdx
);

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              ns;
    logic              hyp;
    logic [1:0]        level;
    logic              host;
  } slot_t;

  slot_t ent [ENTRIES];

  // latched invalidation command
  logic [2:0]        cOp;
  logic [VPN_W-1:0]  cVpn;
  logic [ASID_W-1:0] cAsid;
  logic [VMID_W-1:0] cVmid;
  logic              cSecure;
  logic [1:0]        cLevel;
  logic              cHost;
  logic              cIgnLvl;

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] invMatch;
  logic               lkAny;
  logic [IDX_W-1:0]   lkIdx;
  logic               doPromote;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic secOk, vmOk, lvlOk, vaOk;
    assign validVec[g] = ent[g].valid;

    assign lkMatch[g] = ent[g].valid && (ent[g].vpn == lkVpn)
                        && (lkIgnoreAsid || ent[g].asid == lkAsid)
                        && (ent[g].vmid == lkVmid) && (ent[g].hyp == lkHyp)
                        && (ent[g].ns == !lkSecure)
                        && (ent[g].level == lkLevel) && (ent[g].host == lkHost);

    assign secOk = ent[g].ns == !cSecure;
    assign vmOk  = (ent[g].vmid == cVmid) || cSecure;
    assign lvlOk = (ent[g].level == cLevel) && (ent[g].host == cHost);
    assign vaOk  = (ent[g].vpn == cVpn) && (ent[g].vmid == cVmid)
                   && (ent[g].hyp == (cLevel == 2'd2)) && secOk && lvlOk;

    always_comb begin
      case (invOp_e'(cOp))
        INV_ALL:     invMatch[g] = ent[g].valid && secOk && vmOk && (cIgnLvl || lvlOk);
        INV_ASID:    invMatch[g] = ent[g].valid && secOk && vmOk && lvlOk
                                   && (ent[g].asid == cAsid);
        INV_VA_ASID: invMatch[g] = ent[g].valid && vaOk && (ent[g].asid == cAsid);
        INV_VA_ANY:  invMatch[g] = ent[g].valid && vaOk;
        INV_VMID:    invMatch[g] = ent[g].valid && secOk && (ent[g].vmid == cVmid);
        default:     invMatch[g] = 1'b0;
      endcase
    end
  end

  // lowest matching index wins
  always_comb begin
    lkAny = 1'b0;
    lkIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkAny = 1'b1;
        lkIdx = IDX_W'(i);
      end
    end
  end

  assign doPromote = strb.lkFire && lkAny && !lkProbe && (lkIdx > IDX_W'(MRU_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cOp <= '0; cVpn <= '0; cAsid <= '0; cVmid <= '0;
      cSecure <= 1'b0; cLevel <= '0; cHost <= 1'b0; cIgnLvl <= 1'b0;
    end else if (strb.invStart) begin
      cOp <= invOp; cVpn <= invVpn; cAsid <= invAsid; cVmid <= invVmid;
      cSecure <= invSecure; cLevel <= invLevel; cHost <= invHost;
      cIgnLvl <= invIgnoreLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (strb.refFire) begin
      ent[refIdx] <= '{valid: 1'b1, vpn: refVpn, ppn: refPpn, asid: refAsid,
                       vmid: refVmid, ns: refNs, hyp: refHyp,
                       level: refLevel, host: refHost};
    end else if (doPromote) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (i == 0) ent[0] <= ent[lkIdx];
        else if (IDX_W'(i) <= lkIdx) ent[i] <= ent[i-1];
      end
    end else if (strb.sweepOn && invMatch[sweepIdx]) begin
      ent[sweepIdx].valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPpn   <= '0;
      rspIdx   <= '0;
    end else begin
      rspValid <= strb.lkFire;
      if (strb.lkFire) begin
        rspHit <= lkAny;
        rspPpn <= lkAny ? ent[lkIdx].ppn : '0;
        rspIdx <= lkIdx;
      end
    end
  end

  // R2: response exactly one cycle after acceptance
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.lkFire |=> rspValid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lkFire |=> !rspValid);

  // R3: promoted slot lands at the front
  p_promote_front_r3: assert property (@(posedge clk) disable iff (!rstN)
    doPromote |=> (ent[0].valid && ent[0].vpn == $past(lkVpn)));

  // R6: a swept matching slot is gone afterwards
  p_sweep_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sweepOn && invMatch[sweepIdx]) |=> !ent[$past(sweepIdx)].valid);

  // R10: refilled slot becomes valid
  p_refill_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.refFire |=> ent[$past(refIdx)].valid);

endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_tag_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int MRU_LIMIT = 2,
  parameter bit IS_STAGE2 = 1'b0,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VMID_W-1:0] lkVmid,
  input  logic              lkHyp,
  input  logic              lkSecure,
  input  logic [1:0]        lkLevel,
  input  logic              lkHost,
  input  logic              lkIgnoreAsid,
  input  logic              lkProbe,
  output logic              rspValid,
  output logic              rspHit,
  output logic [PPN_W-1:0]  rspPpn,
  output logic [IDX_W-1:0]  rspIdx,
  input  logic              refValid,
  output logic              refReady,
  input  logic [VPN_W-1:0]  refVpn,
  input  logic [PPN_W-1:0]  refPpn,
  input  logic [ASID_W-1:0] refAsid,
  input  logic [VMID_W-1:0] refVmid,
  input  logic              refNs,
  input  logic              refHyp,
  input  logic [1:0]        refLevel,
  input  logic              refHost,
  input  logic              invValid,
  output logic              invReady,
  input  logic [2:0]        invOp,
  input  logic [VPN_W-1:0]  invVpn,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [VMID_W-1:0] invVmid,
  input  logic              invSecure,
  input  logic [1:0]        invLevel,
  input  logic              invHost,
  input  logic              invIgnoreLevel,
  input  logic              invHypMode,
  output logic              invBusy,
  output logic              fwdAllValid,
  output logic              fwdAllSecure
);

  tlbStrobe_t         strb;
  logic [IDX_W-1:0]   sweepIdx;
  logic [IDX_W-1:0]   refIdx;
  logic [ENTRIES-1:0] validVec;

  tlb_tag_ctrl #(.ENTRIES(ENTRIES), .IS_STAGE2(IS_STAGE2)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .refValid(refValid), .invValid(invValid),
    .invOp(invOp), .invHypMode(invHypMode), .invSecure(invSecure),
    .validVec(validVec),
    .lkReady(lkReady), .refReady(refReady), .invReady(invReady),
    .busy(invBusy), .sweepIdx(sweepIdx), .refIdx(refIdx),
    .fwdAllValid(fwdAllValid), .fwdAllSecure(fwdAllSecure),
    .strb(strb)
  );

  tlb_tag_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
    .VMID_W(VMID_W), .MRU_LIMIT(MRU_LIMIT)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .sweepIdx(sweepIdx), .refIdx(refIdx),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .lkVmid(lkVmid), .lkHyp(lkHyp),
    .lkSecure(lkSecure), .lkLevel(lkLevel), .lkHost(lkHost),
    .lkIgnoreAsid(lkIgnoreAsid), .lkProbe(lkProbe),
    .refVpn(refVpn), .refPpn(refPpn), .refAsid(refAsid), .refVmid(refVmid),
    .refNs(refNs), .refHyp(refHyp), .refLevel(refLevel), .refHost(refHost),
    .invOp(invOp), .invVpn(invVpn), .invAsid(invAsid), .invVmid(invVmid),
    .invSecure(invSecure), .invLevel(invLevel), .invHost(invHost),
    .invIgnoreLevel(invIgnoreLevel),
    .validVec(validVec),
    .rspValid(rspValid), .rspHit(rspHit), .rspPpn(rspPpn), .rspIdx(rspIdx)
  );

endmodule

// File: tb/tlb_tagged_test.sv
module tlb_tagged_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic lkValid = 0, lkReady, lkHyp = 0, lkSecure = 0, lkHost = 0, lkIgnoreAsid = 0, lkProbe = 0;
  logic [19:0] lkVpn = 0;
  logic [7:0] lkAsid = 0, lkVmid = 0;
  logic [1:0] lkLevel = 0;
  logic rspValid, rspHit;
  logic [19:0] rspPpn;
  logic [2:0] rspIdx;
  logic refValid = 0, refReady, refNs = 0, refHyp = 0, refHost = 0;
  logic [19:0] refVpn = 0, refPpn = 0;
  logic [7:0] refAsid = 0, refVmid = 0;
  logic [1:0] refLevel = 0;
  logic invValid = 0, invReady, invSecure = 0, invHost = 0, invIgnoreLevel = 0, invHypMode = 0;
  logic [2:0] invOp = 0;
  logic [19:0] invVpn = 0;
  logic [7:0] invAsid = 0, invVmid = 0;
  logic [1:0] invLevel = 0;
  logic invBusy, fwdAllValid, fwdAllSecure;

  tlb_tagged uut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { bit hit; int idx; logic [19:0] ppn; string req; } exp_t;
  exp_t sbq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sbq.size() == 0) chk("R2 unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk({e.req, " hit"}, 32'(rspHit), 32'(e.hit));
        chk({e.req, " ppn"}, 32'(rspPpn), 32'(e.hit ? e.ppn : 20'd0));
        chk({e.req, " idx"}, 32'(rspIdx), 32'(e.hit ? e.idx : 0));
      end
    end
  end

  task automatic lk(input logic [19:0] vpn, input logic [7:0] asid, input bit expHit,
                    input int expIdx, input logic [19:0] expPpn, input string req,
                    input bit probe = 1, input logic [7:0] vmid = 8'd5, input bit sec = 0,
                    input bit host = 0, input bit ign = 0);
    exp_t e;
    @(negedge clk);
    lkValid = 1; lkVpn = vpn; lkAsid = asid; lkVmid = vmid; lkSecure = sec;
    lkLevel = 2'd1; lkHost = host; lkIgnoreAsid = ign; lkProbe = probe; lkHyp = 0;
    e.hit = expHit; e.idx = expIdx; e.ppn = expPpn; e.req = req;
    while (!lkReady) @(negedge clk);
    sbq.push_back(e);
    @(posedge clk);
    @(negedge clk);
    lkValid = 0;
  endtask

  task automatic rf(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid,
                    input logic [7:0] vmid = 8'd5, input bit host = 0);
    @(negedge clk);
    refValid = 1; refVpn = vpn; refPpn = ppn; refAsid = asid; refVmid = vmid;
    refNs = 1; refHyp = 0; refLevel = 2'd1; refHost = host;
    while (!refReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    refValid = 0;
  endtask

  task automatic inv(input logic [2:0] op, input logic [19:0] vpn, input logic [7:0] asid,
                     input logic [7:0] vmid, input bit sec, input bit host, input bit ignLvl,
                     input bit hypMode, output int busyCnt, output bit fwdV, output bit fwdS);
    @(negedge clk);
    invValid = 1; invOp = op; invVpn = vpn; invAsid = asid; invVmid = vmid;
    invSecure = sec; invLevel = 2'd1; invHost = host; invIgnoreLevel = ignLvl;
    invHypMode = hypMode;
    while (!invReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    invValid = 0;
    fwdV = fwdAllValid; fwdS = fwdAllSecure;
    busyCnt = 0;
    while (invBusy) begin
      if (lkReady || refReady || invReady) chk("R8 ready during sweep", 32'd1, 32'd0);
      busyCnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bc;
    bit fv, fs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lkReady", 32'(lkReady), 32'd1);
    chk("R1 refReady", 32'(refReady), 32'd1);
    chk("R1 invReady", 32'(invReady), 32'd1);
    chk("R1 busy", 32'(invBusy), 32'd0);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 fwd", 32'(fwdAllValid), 32'd0);
    lk(20'h100, 8'd1, 0, 0, 0, "R1 empty miss");

    // R11 arbitration, checked combinationally
    @(negedge clk);
    lkValid = 1; refValid = 1; invValid = 1;
    #1;
    chk("R11 inv first", 32'({invReady, refReady, lkReady}), 32'b100);
    invValid = 0;
    #1;
    chk("R11 refill next", 32'({refReady, lkReady}), 32'b10);
    lkValid = 0; refValid = 0;

    // R10 fill in order
    rf(20'h100, 20'h200, 8'd1);
    rf(20'h101, 20'h201, 8'd2);
    rf(20'h102, 20'h202, 8'd1);
    rf(20'h103, 20'h203, 8'd2);
    rf(20'h104, 20'h204, 8'd1);
    rf(20'h100, 20'h205, 8'd2);
    rf(20'h106, 20'h206, 8'd1, 8'd5, 1'b1);
    rf(20'h100, 20'h207, 8'd1);

    // R2 matching and priority
    lk(20'h100, 8'd1, 1, 0, 20'h200, "R2 lowest index wins");
    lk(20'h100, 8'd2, 1, 5, 20'h205, "R2 asid selects");
    lk(20'h100, 8'd3, 1, 0, 20'h200, "R2 ignore asid", 1, 8'd5, 0, 0, 1);
    lk(20'h106, 8'd1, 0, 0, 0, "R2 host mismatch");
    lk(20'h106, 8'd1, 1, 6, 20'h206, "R2 host match", 1, 8'd5, 0, 1);
    lk(20'h104, 8'd1, 0, 0, 0, "R2 vmid mismatch", 1, 8'd6);
    lk(20'h104, 8'd1, 0, 0, 0, "R2 secure mismatch", 1, 8'd5, 1);

    // R3 promotion
    lk(20'h104, 8'd1, 1, 4, 20'h204, "R3 probe hit");
    lk(20'h104, 8'd1, 1, 4, 20'h204, "R3 probe no move");
    lk(20'h104, 8'd1, 1, 4, 20'h204, "R3 real hit", 0);
    lk(20'h104, 8'd1, 1, 0, 20'h204, "R3 moved to front");
    lk(20'h100, 8'd1, 1, 1, 20'h200, "R3 shifted up");
    lk(20'h101, 8'd2, 1, 2, 20'h201, "R3 at limit", 0);
    lk(20'h101, 8'd2, 1, 2, 20'h201, "R3 at limit stays");
    // order: 104,100a1,101,102,103,100a2,106h,100dup

    // R6 page+asid flush removes two slots; R8 sweep length
    inv(3'd2, 20'h100, 8'd1, 8'd5, 0, 0, 0, 0, bc, fv, fs);
    chk("R8 busy cycles", 32'(bc), 32'(N));
    chk("R9 no fwd for page op", 32'(fv), 32'd0);
    lk(20'h100, 8'd1, 0, 0, 0, "R6 both asid1 copies gone");
    lk(20'h100, 8'd2, 1, 5, 20'h205, "R6 other asid kept");

    // R10 first free slot
    rf(20'h110, 20'h210, 8'd3);
    lk(20'h110, 8'd3, 1, 1, 20'h210, "R10 first free");

    // R5 asid flush
    inv(3'd1, 20'h0, 8'd2, 8'd5, 0, 0, 0, 0, bc, fv, fs);
    lk(20'h103, 8'd2, 0, 0, 0, "R5 asid2 cleared");
    lk(20'h102, 8'd1, 1, 3, 20'h202, "R5 asid1 kept");

    // R6 page any-asid flush
    inv(3'd3, 20'h110, 8'd0, 8'd5, 0, 0, 0, 0, bc, fv, fs);
    lk(20'h110, 8'd3, 0, 0, 0, "R6 any asid cleared");

    // R4/R9 secure flush-all from hyp mode
    inv(3'd0, 20'h0, 8'd0, 8'd5, 1, 0, 0, 1, bc, fv, fs);
    chk("R9 fwd raised", 32'(fv), 32'd1);
    chk("R9 fwd secure", 32'(fs), 32'd1);
    lk(20'h102, 8'd1, 1, 3, 20'h202, "R4 secure flush spares ns");
    inv(3'd0, 20'h0, 8'd0, 8'd9, 0, 0, 0, 0, bc, fv, fs);
    chk("R9 no fwd outside hyp", 32'(fv), 32'd0);
    lk(20'h102, 8'd1, 1, 3, 20'h202, "R4 vmid mismatch spares");
    inv(3'd0, 20'h0, 8'd0, 8'd5, 0, 0, 0, 0, bc, fv, fs);
    lk(20'h102, 8'd1, 0, 0, 0, "R4 flush clears");
    lk(20'h104, 8'd1, 0, 0, 0, "R4 flush clears front");
    lk(20'h106, 8'd1, 1, 6, 20'h206, "R4 host slot kept", 1, 8'd5, 0, 1);
    inv(3'd0, 20'h0, 8'd0, 8'd5, 0, 0, 1, 0, bc, fv, fs);
    lk(20'h106, 8'd1, 0, 0, 0, "R4 ignore level clears", 1, 8'd5, 0, 1);

    // R10 round robin when full
    for (int i = 0; i < N; i++) rf(20'h180 + 20'(i), 20'h280 + 20'(i), 8'd1);
    rf(20'h1FF, 20'h2FF, 8'd1, 8'd7);
    lk(20'h1FF, 8'd1, 1, 0, 20'h2FF, "R10 rr victim 0", 1, 8'd7);
    lk(20'h180, 8'd1, 0, 0, 0, "R10 old slot replaced");
    rf(20'h1FE, 20'h2FE, 8'd1, 8'd7);
    lk(20'h1FE, 8'd1, 1, 1, 20'h2FE, "R10 rr victim 1", 1, 8'd7);

    // R7 vmid flush
    inv(3'd4, 20'h0, 8'd0, 8'd5, 0, 0, 0, 0, bc, fv, fs);
    lk(20'h187, 8'd1, 0, 0, 0, "R7 vmid5 cleared");
    lk(20'h1FF, 8'd1, 1, 0, 20'h2FF, "R7 vmid7 kept", 1, 8'd7);
    inv(3'd6, 20'h1FF, 8'd1, 8'd7, 0, 0, 1, 0, bc, fv, fs);
    lk(20'h1FE, 8'd1, 1, 1, 20'h2FE, "R7 reserved op no effect", 1, 8'd7);
    rf(20'h150, 20'h250, 8'd4);
    lk(20'h150, 8'd4, 1, 2, 20'h250, "R10 free after flush");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", 32'(sbq.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule